// File: doc/BRIEF.md
# IOMMU Translation Probe Port

This block gives software a way to ask the address translation machinery of an IOMMU what it would do with one I/O virtual address, without sending a real DMA. Software loads the address into one memory-mapped register. It then writes a control word that names the device, the process and whether the access would be read-only. Setting the start bit in that same write launches the request. The start bit then reads back as a busy flag until the answer is ready.

While busy, the block presents exactly one request to an external translation engine over a valid/ready handshake. It then waits for a one-cycle result pulse. It folds the result into a single 64-bit answer word: either a physical page number, or a fault flag with a cause code. When no device/process context exists, the fault reports a fixed "DMA disabled" cause. Clearing the busy flag tells software that the answer word is valid. A capability word advertises the feature with a bit that is always set.

Top module: `iommu_dbg_probe`

## Requirements
- R1: After reset, the address (offset 0x258), control (0x260) and answer (0x268) registers read as zero, and no request is presented.
- R2: A write to the control register with bit 0 set while idle does three things. It latches the flag in bit 3, the process ID in bits 31:12 and the device ID in bits 63:40. It sets bit 0 as the busy flag. From the next cycle it presents a request carrying the stored address, device ID and process ID.
- R3: A control write with bit 0 clear issues no request and changes no register.
- R4: The request's read-only output equals the stored bit 3 of the control word. It is 1 for a read-only probe and 0 for a read-write probe.
- R5: A presented request stays valid, with unchanged fields, until it is accepted by ready. It drops in the cycle after acceptance, and only one request is ever outstanding.
- R6: In the cycle after a result pulse that ends a probe, control bit 0 reads 0. The other control fields are kept.
- R7: A faulting result writes an answer with bit 0 = 1, the 10-bit cause in bits 19:10, and all other bits 0.
- R8: A result flagged as "no context" writes a fault answer whose cause is the DMA-disabled code (256). The engine's cause input is ignored in that case.
- R9: A successful result writes the physical address bits [55:12] into answer bits 53:10. Bit 0 (fault) is 0, bit 9 (large page) is 0, and all other bits are 0.
- R10: Reading offset 0x000 returns the capability word with bit 31 set.
- R11: While busy, writes to the address register and to the control register are ignored. This also holds for a write in the same cycle that the result arrives.
- R12: Writes to the answer register are ignored.
- R13: A result pulse that arrives before the request has been accepted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_wr_en | input | 1 | Register write strobe |
| mmio_wr_addr | input | ADDR_W | Register write offset |
| mmio_wr_data | input | 64 | Register write data |
| mmio_rd_addr | input | ADDR_W | Register read offset |
| mmio_rd_data | output | 64 | Register read data (combinational) |
| xq_valid | output | 1 | Translation request valid |
| xq_ready | input | 1 | Translation request accepted |
| xq_iova | output | 64 | Address to translate |
| xq_dev_id | output | 24 | Device ID of the request |
| xq_proc_id | output | 20 | Process ID of the request |
| xq_read_only | output | 1 | 1: read-only probe, 0: read-write probe |
| xr_valid | input | 1 | Single-cycle result pulse |
| xr_fault | input | 1 | Result is a translation fault |
| xr_ctx_miss | input | 1 | No device/process context was found |
| xr_cause | input | 10 | Fault cause code |
| xr_paddr | input | PA_W | Translated physical address |

## Verification
The result pulse that ends a probe can arrive in the same cycle as a software write to the address register. The bench drives both at one clock edge. It expects the write to be lost, because the busy flag is still set at that edge. In the following cycle it expects the busy flag to be clear and the answer word to be filled. A second collision, a result pulse while the request still waits for ready, is driven and expected to leave the answer and busy flag untouched.

// File: rtl/iommu_dbg_pkg.sv
package iommu_dbg_pkg;

    localparam int unsigned REG_W         = 64;
    // control word layout
    localparam int unsigned CTL_GO_BIT    = 0;
    localparam int unsigned CTL_NW_BIT    = 3;
    localparam int unsigned CTL_PID_LSB   = 12;
    localparam int unsigned PID_W         = 20;
    localparam int unsigned CTL_DID_LSB   = 40;
    localparam int unsigned DID_W         = 24;
    // answer word layout
    localparam int unsigned RSP_FAULT_BIT = 0;
    localparam int unsigned RSP_SP_BIT    = 9;
    localparam int unsigned RSP_FIELD_LSB = 10;
    localparam int unsigned RSP_PPN_W     = 44;
    localparam int unsigned PAGE_SHIFT    = 12;
    localparam int unsigned CAUSE_W       = 10;
    // capability
    localparam int unsigned CAP_DBG_BIT   = 31;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } probe_phase_e;

    typedef struct packed {
        probe_phase_e phase;
    } probe_fsm_t;

    typedef struct packed {
        logic [REG_W-1:0] iova;
        logic             nw;
        logic [PID_W-1:0] pid;
        logic [DID_W-1:0] did;
        logic [REG_W-1:0] resp;
    } probe_regs_t;

endpackage

// File: rtl/iommu_dbg_pack.sv
module iommu_dbg_pack
    import iommu_dbg_pkg::*;
#(
    parameter int unsigned         PA_W          = 56,
    parameter logic [CAUSE_W-1:0]  CAUSE_DMA_OFF = 10'd256
) (
    input  logic               fault,
    input  logic               ctx_miss,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [PA_W-1:0]    paddr,
    output logic [REG_W-1:0]   word
);

    localparam int unsigned PPN_SRC_W = PA_W - PAGE_SHIFT;

    logic [RSP_PPN_W-1:0] ppn;
    logic                 unused_page_offset;

    assign unused_page_offset = ^paddr[PAGE_SHIFT-1:0];

    generate
        if (PPN_SRC_W >= RSP_PPN_W) begin : g_ppn_trunc
            assign ppn = paddr[PAGE_SHIFT +: RSP_PPN_W];
        end else begin : g_ppn_ext
            assign ppn = {{(RSP_PPN_W-PPN_SRC_W){1'b0}}, paddr[PA_W-1:PAGE_SHIFT]};
        end
    endgenerate

    always_comb begin
        word = '0;
        if (ctx_miss) begin
            word[RSP_FAULT_BIT]                  = 1'b1;
            word[RSP_FIELD_LSB +: CAUSE_W]       = CAUSE_DMA_OFF;
        end else if (fault) begin
            word[RSP_FAULT_BIT]                  = 1'b1;
            word[RSP_FIELD_LSB +: CAUSE_W]       = cause;
        end else begin
            word[RSP_FIELD_LSB +: RSP_PPN_W]     = ppn;
            word[RSP_SP_BIT]                     = 1'b0;
        end
    end

endmodule

// File: rtl/iommu_dbg_fsm.sv
module iommu_dbg_fsm
    import iommu_dbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic xq_ready,
    input  logic xr_valid,
    output logic xq_valid,
    output logic busy,
    output logic done
);

    probe_fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.phase)
            PH_IDLE:  if (start)    f_d.phase = PH_ISSUE;
            PH_ISSUE: if (xq_ready) f_d.phase = PH_WAIT;
            PH_WAIT:  if (xr_valid) f_d.phase = PH_IDLE;
            default:                f_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.phase <= PH_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign xq_valid = (f_q.phase == PH_ISSUE);
    assign busy     = (f_q.phase != PH_IDLE);
    assign done     = (f_q.phase == PH_WAIT) && xr_valid;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xq_valid && !xq_ready) |=> xq_valid); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (xq_valid && xq_ready) |=> !xq_valid); // R5
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_START_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> xq_valid); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R11

endmodule

// File: rtl/iommu_dbg_regs.sv
module iommu_dbg_regs
    import iommu_dbg_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  OFS_CAP  = 'h000,
    parameter logic [ADDR_W-1:0]  OFS_IOVA = 'h258,
    parameter logic [ADDR_W-1:0]  OFS_CTL  = 'h260,
    parameter logic [ADDR_W-1:0]  OFS_RESP = 'h268,
    parameter logic [REG_W-1:0]   CAP_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              busy,
    input  logic              done,
    input  logic [REG_W-1:0]  done_word,
    output logic              start,
    output logic [REG_W-1:0]  req_iova,
    output logic              req_nw,
    output logic [PID_W-1:0]  req_pid,
    output logic [DID_W-1:0]  req_did,
    output logic [REG_W-1:0]  resp_word
);

    probe_regs_t r_d, r_q;
    logic [REG_W-1:0] ctl_view;
    logic [REG_W-1:0] cap_view;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (done) begin
            r_d.resp = done_word;
        end
        if (wr_en && !busy) begin
            if (wr_addr == OFS_IOVA) begin
                r_d.iova = wr_data;
            end else if (wr_addr == OFS_CTL && wr_data[CTL_GO_BIT]) begin
                r_d.nw  = wr_data[CTL_NW_BIT];
                r_d.pid = wr_data[CTL_PID_LSB +: PID_W];
                r_d.did = wr_data[CTL_DID_LSB +: DID_W];
                start   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctl_view                          = '0;
        ctl_view[CTL_GO_BIT]              = busy;
        ctl_view[CTL_NW_BIT]              = r_q.nw;
        ctl_view[CTL_PID_LSB +: PID_W]    = r_q.pid;
        ctl_view[CTL_DID_LSB +: DID_W]    = r_q.did;
        cap_view                          = CAP_BASE;
        cap_view[CAP_DBG_BIT]             = 1'b1;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == OFS_CAP)       rd_data = cap_view;
        else if (rd_addr == OFS_IOVA) rd_data = r_q.iova;
        else if (rd_addr == OFS_CTL)  rd_data = ctl_view;
        else if (rd_addr == OFS_RESP) rd_data = r_q.resp;
    end

    assign req_iova  = r_q.iova;
    assign req_nw    = r_q.nw;
    assign req_pid   = r_q.pid;
    assign req_did   = r_q.did;
    assign resp_word = r_q.resp;

    AST_IOVA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == OFS_IOVA) |=> $stable(r_q.iova)); // R11
    AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == OFS_CTL) |=> ($stable(r_q.pid) && $stable(r_q.did) && $stable(r_q.nw))); // R11
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(r_q.resp)); // R12
    AST_CAP_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFS_CAP) |-> rd_data[CAP_DBG_BIT]); // R10

endmodule

// File: rtl/iommu_dbg_probe.sv
module iommu_dbg_probe
    import iommu_dbg_pkg::*;
#(
    parameter int unsigned        ADDR_W        = 12,
    parameter int unsigned        PA_W          = 56,
    parameter logic [ADDR_W-1:0]  OFS_CAP       = 'h000,
    parameter logic [ADDR_W-1:0]  OFS_IOVA      = 'h258,
    parameter logic [ADDR_W-1:0]  OFS_CTL       = 'h260,
    parameter logic [ADDR_W-1:0]  OFS_RESP      = 'h268,
    parameter logic [63:0]        CAP_BASE      = '0,
    parameter logic [9:0]         CAUSE_DMA_OFF = 10'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmio_wr_en,
    input  logic [ADDR_W-1:0] mmio_wr_addr,
    input  logic [63:0]       mmio_wr_data,
    input  logic [ADDR_W-1:0] mmio_rd_addr,
    output logic [63:0]       mmio_rd_data,
    output logic              xq_valid,
    input  logic              xq_ready,
    output logic [63:0]       xq_iova,
    output logic [23:0]       xq_dev_id,
    output logic [19:0]       xq_proc_id,
    output logic              xq_read_only,
    input  logic              xr_valid,
    input  logic              xr_fault,
    input  logic              xr_ctx_miss,
    input  logic [9:0]        xr_cause,
    input  logic [PA_W-1:0]   xr_paddr
);

    logic             start;
    logic             busy;
    logic             done;
    logic             req_nw;
    logic [REG_W-1:0] done_word;
    logic [REG_W-1:0] resp_word;

    iommu_dbg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .xq_ready (xq_ready),
        .xr_valid (xr_valid),
        .xq_valid (xq_valid),
        .busy     (busy),
        .done     (done)
    );

    iommu_dbg_pack #(
        .PA_W          (PA_W),
        .CAUSE_DMA_OFF (CAUSE_DMA_OFF)
    ) u_pack (
        .fault    (xr_fault),
        .ctx_miss (xr_ctx_miss),
        .cause    (xr_cause),
        .paddr    (xr_paddr),
        .word     (done_word)
    );

    iommu_dbg_regs #(
        .ADDR_W   (ADDR_W),
        .OFS_CAP  (OFS_CAP),
        .OFS_IOVA (OFS_IOVA),
        .OFS_CTL  (OFS_CTL),
        .OFS_RESP (OFS_RESP),
        .CAP_BASE (CAP_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mmio_wr_en),
        .wr_addr   (mmio_wr_addr),
        .wr_data   (mmio_wr_data),
        .rd_addr   (mmio_rd_addr),
        .rd_data   (mmio_rd_data),
        .busy      (busy),
        .done      (done),
        .done_word (done_word),
        .start     (start),
        .req_iova  (xq_iova),
        .req_nw    (req_nw),
        .req_pid   (xq_proc_id),
        .req_did   (xq_dev_id),
        .resp_word (resp_word)
    );

    assign xq_read_only = req_nw;

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (xr_fault || xr_ctx_miss)) |=> resp_word[RSP_FAULT_BIT]); // R7
    AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && xr_ctx_miss) |=> (resp_word[RSP_FIELD_LSB +: CAUSE_W] == CAUSE_DMA_OFF)); // R8
    AST_OK_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !xr_fault && !xr_ctx_miss) |=> (resp_word[RSP_FIELD_LSB-1:0] == '0)); // R9
    AST_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_valid && xq_valid) |=> (busy && $stable(resp_word))); // R13

endmodule

// File: tb/tb_iommu_dbg_probe.sv
module tb_iommu_dbg_probe;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CAP = 12'h000, A_IOVA = 12'h258, A_CTL = 12'h260, A_RESP = 12'h268;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmio_wr_en = 1'b0;
    logic [11:0] mmio_wr_addr = '0;
    logic [63:0] mmio_wr_data = '0;
    logic [11:0] mmio_rd_addr = '0;
    logic [63:0] mmio_rd_data;
    logic        xq_valid;
    logic        xq_ready = 1'b0;
    logic [63:0] xq_iova;
    logic [23:0] xq_dev_id;
    logic [19:0] xq_proc_id;
    logic        xq_read_only;
    logic        xr_valid = 1'b0;
    logic        xr_fault = 1'b0;
    logic        xr_ctx_miss = 1'b0;
    logic [9:0]  xr_cause = '0;
    logic [55:0] xr_paddr = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [63:0] m_iova, m_resp;
    logic        m_nw;
    logic [19:0] m_pid;
    logic [23:0] m_did;
    int          m_phase; // 0 idle, 1 presenting, 2 awaiting result

    always #(CLK_PERIOD/2) clk = ~clk;

    iommu_dbg_probe dut (
        .clk(clk), .rst_n(rst_n),
        .mmio_wr_en(mmio_wr_en), .mmio_wr_addr(mmio_wr_addr), .mmio_wr_data(mmio_wr_data),
        .mmio_rd_addr(mmio_rd_addr), .mmio_rd_data(mmio_rd_data),
        .xq_valid(xq_valid), .xq_ready(xq_ready), .xq_iova(xq_iova),
        .xq_dev_id(xq_dev_id), .xq_proc_id(xq_proc_id), .xq_read_only(xq_read_only),
        .xr_valid(xr_valid), .xr_fault(xr_fault), .xr_ctx_miss(xr_ctx_miss),
        .xr_cause(xr_cause), .xr_paddr(xr_paddr)
    );

    function automatic logic [63:0] ctl_word(input logic go, input logic nw,
                                             input logic [19:0] pid, input logic [23:0] did);
        logic [63:0] w;
        w = '0;
        w[0] = go;
        w[3] = nw;
        w[31:12] = pid;
        w[63:40] = did;
        return w;
    endfunction

    function automatic logic [63:0] answer(input logic f, input logic miss,
                                           input logic [9:0] c, input logic [55:0] pa);
        if (miss)   return 64'd1 | (64'd256 << 10);
        else if (f) return 64'd1 | ({54'd0, c} << 10);
        else        return {10'd0, pa[55:12], 10'd0};
    endfunction

    function automatic logic [63:0] model_read(input logic [11:0] a);
        if (a == A_CAP)  return 64'h8000_0000;
        if (a == A_IOVA) return m_iova;
        if (a == A_CTL)  return ctl_word(m_phase != 0, m_nw, m_pid, m_did);
        if (a == A_RESP) return m_resp;
        return 64'd0;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model advances on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_iova = '0; m_resp = '0; m_nw = 1'b0; m_pid = '0; m_did = '0; m_phase = 0;
        end else begin
            int ph;
            ph = m_phase;
            if (ph == 2 && xr_valid) begin
                m_resp  = answer(xr_fault, xr_ctx_miss, xr_cause, xr_paddr);
                m_phase = 0;
            end else if (ph == 1 && xq_ready) begin
                m_phase = 2;
            end
            if (ph == 0 && mmio_wr_en) begin
                if (mmio_wr_addr == A_IOVA) begin
                    m_iova = mmio_wr_data;
                end else if (mmio_wr_addr == A_CTL && mmio_wr_data[0]) begin
                    m_nw = mmio_wr_data[3];
                    m_pid = mmio_wr_data[31:12];
                    m_did = mmio_wr_data[63:40];
                    m_phase = 1;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({63'd0, xq_valid}, {63'd0, m_phase == 1}, "R5 request valid vs model");
            if (m_phase == 1) begin
                chk(xq_iova, m_iova, "R2 request address vs model");
                chk({40'd0, xq_dev_id}, {40'd0, m_did}, "R2 device id vs model");
                chk({44'd0, xq_proc_id}, {44'd0, m_pid}, "R2 process id vs model");
                chk({63'd0, xq_read_only}, {63'd0, m_nw}, "R4 read-only vs model");
            end
            chk(mmio_rd_data, model_read(mmio_rd_addr), "R6 register view vs model");
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
        mmio_wr_en = 1'b0;
        xr_valid   = 1'b0;
        xr_fault   = 1'b0;
        xr_ctx_miss = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        mmio_wr_en = 1'b1;
        mmio_wr_addr = a;
        mmio_wr_data = d;
    endtask

    task automatic peek(input logic [11:0] a, input logic [63:0] exp, input string tag);
        mmio_rd_addr = a;
        #1;
        chk(mmio_rd_data, exp, tag);
    endtask

    localparam logic [63:0] IOVA1 = 64'h0000_1234_5678_9000;
    localparam logic [63:0] IOVA2 = 64'hFFFF_0000_AAAA_B000;
    localparam logic [55:0] PA1   = 56'hAB_CDEF_1234_5678;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        peek(A_IOVA, 64'd0, "R1 address after reset");
        peek(A_CTL,  64'd0, "R1 control after reset");
        peek(A_RESP, 64'd0, "R1 answer after reset");
        chk({63'd0, xq_valid}, 64'd0, "R1 no request after reset");
        // R10 capability
        peek(A_CAP, 64'h8000_0000, "R10 capability bit 31");

        wr(A_IOVA, IOVA1);
        cyc();
        peek(A_IOVA, IOVA1, "R2 address stored");
        // R3 control write without start bit
        wr(A_CTL, ctl_word(1'b0, 1'b1, 20'h11111, 24'h222222));
        cyc();
        peek(A_CTL, 64'd0, "R3 control unchanged");
        chk({63'd0, xq_valid}, 64'd0, "R3 no request");

        // R2 start a read-only probe
        wr(A_CTL, ctl_word(1'b1, 1'b1, 20'hABCDE, 24'h123456));
        cyc();
        chk({63'd0, xq_valid}, 64'd1, "R2 request presented");
        chk(xq_iova, IOVA1, "R2 request address");
        chk({40'd0, xq_dev_id}, 64'h123456, "R2 device id");
        chk({44'd0, xq_proc_id}, 64'hABCDE, "R2 process id");
        chk({63'd0, xq_read_only}, 64'd1, "R4 read-only request");
        peek(A_CTL, ctl_word(1'b1, 1'b1, 20'hABCDE, 24'h123456), "R2 busy readback");

        // R11 writes while busy
        wr(A_IOVA, IOVA2);
        cyc();
        peek(A_IOVA, IOVA1, "R11 address locked");
        wr(A_CTL, ctl_word(1'b1, 1'b0, 20'h00001, 24'h000002));
        cyc();
        peek(A_CTL, ctl_word(1'b1, 1'b1, 20'hABCDE, 24'h123456), "R11 control locked");
        chk({44'd0, xq_proc_id}, 64'hABCDE, "R5 fields held while unaccepted");
        // R13 early result pulse
        xr_valid = 1'b1; xr_fault = 1'b1; xr_cause = 10'd3;
        cyc();
        peek(A_RESP, 64'd0, "R13 early result ignored");
        chk({63'd0, xq_valid}, 64'd1, "R13 request still presented");

        // R5 accept
        xq_ready = 1'b1;
        cyc();
        xq_ready = 1'b0;
        chk({63'd0, xq_valid}, 64'd0, "R5 request dropped after accept");

        // success result colliding with an address write (R11, R9, R6)
        xr_valid = 1'b1; xr_paddr = PA1; xr_cause = 10'h3FF;
        wr(A_IOVA, IOVA2);
        cyc();
        peek(A_CTL, ctl_word(1'b0, 1'b1, 20'hABCDE, 24'h123456), "R6 busy cleared");
        peek(A_RESP, 64'h002A_F37B_C48D_1400, "R9 page number answer");
        peek(A_IOVA, IOVA1, "R11 write at completion lost");

        // R12 answer is read-only
        wr(A_RESP, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc();
        peek(A_RESP, 64'h002A_F37B_C48D_1400, "R12 answer write ignored");

        // read-write probe that faults (R4, R7)
        wr(A_IOVA, IOVA2);
        cyc();
        wr(A_CTL, ctl_word(1'b1, 1'b0, 20'h0F0F0, 24'hA5A5A5));
        cyc();
        chk({63'd0, xq_read_only}, 64'd0, "R4 read-write request");
        chk(xq_iova, IOVA2, "R2 second request address");
        xq_ready = 1'b1;
        cyc();
        xq_ready = 1'b0;
        xr_valid = 1'b1; xr_fault = 1'b1; xr_cause = 10'h0C5; xr_paddr = 56'hFF_FFFF_FFFF_FFFF;
        cyc();
        peek(A_RESP, 64'h0000_0000_0003_1401, "R7 fault answer");
        peek(A_CTL, ctl_word(1'b0, 1'b0, 20'h0F0F0, 24'hA5A5A5), "R6 busy cleared after fault");

        // missing context (R8)
        wr(A_CTL, ctl_word(1'b1, 1'b0, 20'h00007, 24'h000009));
        cyc();
        xq_ready = 1'b1;
        cyc();
        xq_ready = 1'b0;
        xr_valid = 1'b1; xr_ctx_miss = 1'b1; xr_cause = 10'd5;
        cyc();
        peek(A_RESP, 64'h0000_0000_0004_0001, "R8 context-miss answer");
        cyc();
        cyc();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule